// File: doc/BRIEF.md
# Multi-Mode Countdown and Watchdog Timer

This block is a register-mapped countdown timer. A 16-bit counter steps down on the ticks of a programmable clock divider, and a 2-bit mode field decides what happens when it expires. It can wrap and keep running, reload and repeat, stop after a single expiry, or act as a watchdog that asks the system for a reset. Software talks to it through simple write and read strobes, an 8-bit byte offset and 32-bit data.

Every expiry gives a one-cycle interrupt pulse and sets a sticky expiry flag. In watchdog mode an expiry also holds a reset-request output high for a fixed number of cycles. It also sets a reset-cause flag. Only power-on reset or a write-one-to-clear access clears that flag, so software can read it after the system restarts. Writing the load register restarts the count at once, and this write is the keep-alive kick in watchdog mode.

Top module: `tmr_wdog`

## Requirements
- R1: After power-on reset, every register reads 0, `irq` is low and `sys_rst_req` is low.
- R2: A write to offset 0x00 stores bits 15:0 as the reload value and sets the count to that value on the next cycle, even while the timer is running. A read of offset 0x00 returns the current count in bits 15:0.
- R3: Offset 0x08 is the control register. Bit 7 is run, bits 5:4 are mode and bits 3:0 are the divider code. Reads return these fields with all other bits 0. When run is 0 the count holds its value.
- R4: Divider code c below 15 moves the count once every 2^c clock cycles. Code 15 moves it once every 65536 cycles. The divider phase restarts on a load write.
- R5: An expiry is a divider tick that finds the count at 0. In free-running mode (mode 0) the count then becomes 0xFFFF, and `irq` is high for exactly the one cycle after the expiry.
- R6: In periodic mode (mode 1) an expiry reloads the stored reload value and pulses `irq`, and this repeats on every period.
- R7: In one-shot mode (mode 2) an expiry pulses `irq` once, clears the run bit and leaves the count at 0.
- R8: In watchdog mode (mode 3) an expiry reloads the reload value and drives `sys_rst_req` high for exactly 4 cycles. Load writes made before the count reaches 0 prevent any request. A kick in the expiry cycle itself wins over the expiry.
- R9: Offset 0x04 bit 1 is the reset-cause flag. A watchdog expiry sets it. It stays set until power-on reset or a write with bit 1 at 1, and writing 0 leaves it alone.
- R10: Offset 0x04 bit 5 is the expiry flag. Any expiry sets it, and it clears only on a write with bit 5 at 1.
- R11: Reads at any offset other than 0x00, 0x04 and 0x08 return 0. Writes there change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, asynchronous, active low |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe; `rdata` is valid in the same cycle |
| addr | input | 8 | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, zero when `rd_en` is low |
| irq | output | 1 | One-cycle pulse on each expiry |
| sys_rst_req | output | 1 | Reset request, held for 4 cycles after a watchdog expiry |

## Verification
Assertions check these rules on every cycle:
- The count moves only on a tick or a load write.
- A load always lands in the count.
- Each mode gives the right value after an expiry.
- One-shot mode drops the run bit.
- A watchdog expiry raises the request and the cause flag.
- Both status flags are sticky.
- No two divider ticks come back to back above divide-by-one.

Only the bench scenarios can show the exact periods and cycle counts: divide-by-4 and divide-by-65536 spacing, the four-cycle request width, a single pulse in one-shot mode, that a stream of kicks keeps the request low, and that the write-one-to-clear accesses and unmapped accesses behave as specified.

// File: rtl/tmr_wdog_pkg.sv
package tmr_wdog_pkg;

  typedef enum logic [1:0] {
    MODE_FREE     = 2'd0,
    MODE_PERIODIC = 2'd1,
    MODE_ONESHOT  = 2'd2,
    MODE_WATCHDOG = 2'd3
  } tmr_mode_e;

  // register byte offsets
  localparam logic [7:0] OFS_LOAD = 8'h00;
  localparam logic [7:0] OFS_STAT = 8'h04;
  localparam logic [7:0] OFS_CTRL = 8'h08;

  // control fields
  localparam int CTL_RUN_BIT  = 7;
  localparam int CTL_MODE_LSB = 4;
  localparam int CTL_DIV_LSB  = 0;

  // status fields
  localparam int STAT_CAUSE_BIT  = 1;
  localparam int STAT_EXPIRY_BIT = 5;

endpackage

// File: rtl/tmr_wdog_prescale.sv
module tmr_wdog_prescale #(
  parameter int CODE_W = 4,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              restart,
  input  logic [CODE_W-1:0] code,
  output logic              tick
);

  localparam int TOP_CODE = (1 << CODE_W) - 1;

  logic [DIV_W-1:0] phase_q, phase_d, mask;

  // the top code selects the full divider width, lower codes 2^code
  always_comb begin
    for (int i = 0; i < DIV_W; i++) begin
      mask[i] = (int'(code) == TOP_CODE) || (i < int'(code));
    end
  end

  assign tick = run && ((phase_q & mask) == mask);

  always_comb begin
    if (!run || restart) phase_d = '0;
    else                 phase_d = phase_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

  // R4
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && code != '0 && !restart && run) |=> !tick);

endmodule

// File: rtl/tmr_wdog_core.sv
module tmr_wdog_core
  import tmr_wdog_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  tmr_mode_e        mode,
  input  logic             load_wr,
  input  logic [CNT_W-1:0] load_data,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] count,
  output logic             expire
);

  logic [CNT_W-1:0] count_q, count_d;

  // a kick in the same cycle beats the expiry
  assign expire = tick && !load_wr && (count_q == '0);
  assign count  = count_q;

  always_comb begin
    count_d = count_q;
    if (load_wr) begin
      count_d = load_data;
    end else if (tick) begin
      if (count_q != '0) begin
        count_d = count_q - 1'b1;
      end else begin
        unique case (mode)
          MODE_FREE:     count_d = '1;
          MODE_PERIODIC: count_d = reload_val;
          MODE_WATCHDOG: count_d = reload_val;
          default:       count_d = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_d;
  end

  // R2
  load_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_wr |=> count_q == $past(load_data));

  // R3
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_wr && !tick) |=> $stable(count_q));

  // R5
  free_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && mode == MODE_FREE) |=> count_q == '1);

  // R6
  periodic_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && mode == MODE_PERIODIC) |=> count_q == $past(reload_val));

endmodule

// File: rtl/tmr_wdog.sv
module tmr_wdog
  import tmr_wdog_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 16,
  parameter int CODE_W  = 4,
  parameter int DIV_W   = 16,
  parameter int RST_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq,
  output logic              sys_rst_req
);

  localparam int RC_W = $clog2(RST_CYC + 1);

  logic load_wr, stat_wr, ctrl_wr;
  logic hit_load, hit_stat, hit_ctrl;

  logic              run_q, run_d;
  tmr_mode_e         mode_q, mode_d;
  logic [CODE_W-1:0] div_q, div_d;
  logic [CNT_W-1:0]  reload_q, reload_d;
  logic              cause_q, cause_d;
  logic              evt_q, evt_d;
  logic              irq_q, irq_d;
  logic [RC_W-1:0]   rcnt_q, rcnt_d;

  logic             tick, expire, wd_expire;
  logic [CNT_W-1:0] count;
  logic [DATA_W-1:0] rdata_d;

  logic unused_wdata_hi;
  assign unused_wdata_hi = ^wdata[DATA_W-1:CNT_W];

  // decode
  assign hit_load = (addr == ADDR_W'(OFS_LOAD));
  assign hit_stat = (addr == ADDR_W'(OFS_STAT));
  assign hit_ctrl = (addr == ADDR_W'(OFS_CTRL));
  assign load_wr  = wr_en && hit_load;
  assign stat_wr  = wr_en && hit_stat;
  assign ctrl_wr  = wr_en && hit_ctrl;

  tmr_wdog_prescale #(
    .CODE_W (CODE_W),
    .DIV_W  (DIV_W)
  ) u_prescale (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run_q),
    .restart (load_wr),
    .code    (div_q),
    .tick    (tick)
  );

  tmr_wdog_core #(
    .CNT_W (CNT_W)
  ) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .mode       (mode_q),
    .load_wr    (load_wr),
    .load_data  (wdata[CNT_W-1:0]),
    .reload_val (reload_q),
    .count      (count),
    .expire     (expire)
  );

  assign wd_expire = expire && (mode_q == MODE_WATCHDOG);

  // next state
  always_comb begin
    run_d    = run_q;
    mode_d   = mode_q;
    div_d    = div_q;
    reload_d = reload_q;
    if (ctrl_wr) begin
      run_d  = wdata[CTL_RUN_BIT];
      mode_d = tmr_mode_e'(wdata[CTL_MODE_LSB +: 2]);
      div_d  = wdata[CTL_DIV_LSB +: CODE_W];
    end else if (expire && mode_q == MODE_ONESHOT) begin
      run_d = 1'b0;
    end
    if (load_wr) reload_d = wdata[CNT_W-1:0];

    cause_d = (cause_q && !(stat_wr && wdata[STAT_CAUSE_BIT])) || wd_expire;
    evt_d   = (evt_q && !(stat_wr && wdata[STAT_EXPIRY_BIT])) || expire;
    irq_d   = expire;

    if (wd_expire)          rcnt_d = RC_W'(RST_CYC);
    else if (rcnt_q != '0)  rcnt_d = rcnt_q - 1'b1;
    else                    rcnt_d = '0;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      mode_q   <= MODE_FREE;
      div_q    <= '0;
      reload_q <= '0;
      cause_q  <= 1'b0;
      evt_q    <= 1'b0;
      irq_q    <= 1'b0;
      rcnt_q   <= '0;
    end else begin
      run_q    <= run_d;
      mode_q   <= mode_d;
      div_q    <= div_d;
      reload_q <= reload_d;
      cause_q  <= cause_d;
      evt_q    <= evt_d;
      irq_q    <= irq_d;
      rcnt_q   <= rcnt_d;
    end
  end

  assign irq         = irq_q;
  assign sys_rst_req = (rcnt_q != '0);

  // read mux
  always_comb begin
    rdata_d = '0;
    if (hit_load) begin
      rdata_d[CNT_W-1:0] = count;
    end else if (hit_stat) begin
      rdata_d[STAT_CAUSE_BIT]  = cause_q;
      rdata_d[STAT_EXPIRY_BIT] = evt_q;
    end else if (hit_ctrl) begin
      rdata_d[CTL_RUN_BIT]             = run_q;
      rdata_d[CTL_MODE_LSB +: 2]       = mode_q;
      rdata_d[CTL_DIV_LSB +: CODE_W]   = div_q;
    end
  end
  assign rdata = rd_en ? rdata_d : '0;

  // R7
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && mode_q == MODE_ONESHOT && !ctrl_wr) |=> !run_q);

  // R8
  wd_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_expire |=> (sys_rst_req && cause_q));

  // R9
  cause_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_q && !(stat_wr && wdata[STAT_CAUSE_BIT])) |=> cause_q);

  // R10
  expiry_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_q && !(stat_wr && wdata[STAT_EXPIRY_BIT])) |=> evt_q);

endmodule

// File: tb/test_tmr_wdog.sv
module test_tmr_wdog;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic        rd_en;
  logic [7:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq;
  logic        sys_rst_req;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  tmr_wdog i_tmr_wdog (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .addr        (addr),
    .wdata       (wdata),
    .rdata       (rdata),
    .irq         (irq),
    .sys_rst_req (sys_rst_req)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // driver: write access, one cycle
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  // driver: read access, pushes the expected item for the monitor
  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    rd_en = 1'b1; addr = a;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: compares each read against the scoreboard queue
  always @(negedge clk) begin
    #3;
    if (rd_en) begin
      if (exp_q.size() == 0) begin
        chk(rdata, 32'hx, "scoreboard underflow");
      end else begin
        chk(rdata, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    idle(4);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    chk({31'd0, irq}, 32'd0, "R1 irq");
    chk({31'd0, sys_rst_req}, 32'd0, "R1 rst_req");
    rd(8'h00, 32'h0, "R1 count");
    rd(8'h04, 32'h0, "R1 status");
    rd(8'h08, 32'h0, "R1 control");

    // R3 control fields, R11 unmapped offsets
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h08, 32'h0000_00BF, "R3 control readback");
    wr(8'h08, 32'h0);
    rd(8'h08, 32'h0, "R3 control cleared");
    wr(8'h0C, 32'hFFFF_FFFF);
    rd(8'h00, 32'h0, "R11 count untouched");
    rd(8'h08, 32'h0, "R11 control untouched");
    rd(8'h0C, 32'h0, "R11 read 0x0C");
    rd(8'h10, 32'h0, "R11 read 0x10");

    // R3 disable holds count, R2 load while running
    wr(8'h00, 32'd100);
    wr(8'h08, 32'h80);
    idle(9);
    wr(8'h08, 32'h00);
    idle(5);
    rd(8'h00, 32'd90, "R3 hold while stopped");
    wr(8'h08, 32'h80);
    rd(8'h00, 32'd90, "R3 resume value");
    wr(8'h00, 32'h1234);
    rd(8'h00, 32'h1234, "R2 reload while running");
    rd(8'h00, 32'h1233, "R2 count after reload");
    wr(8'h08, 32'h00);

    // R4 divide by 4
    wr(8'h00, 32'd10);
    wr(8'h08, 32'h82);
    idle(3);
    rd(8'h00, 32'd10, "R4 before first tick");
    rd(8'h00, 32'd9, "R4 first tick");
    idle(3);
    rd(8'h00, 32'd8, "R4 second tick");
    wr(8'h08, 32'h00);

    // R5 free-running wrap, R10 expiry flag
    wr(8'h00, 32'd3);
    wr(8'h08, 32'h80);
    idle(3);
    chk({31'd0, irq}, 32'd0, "R5 no irq before expiry");
    rd(8'h00, 32'd0, "R5 count at zero");
    chk({31'd0, irq}, 32'd1, "R5 irq pulse");
    rd(8'h00, 32'h0000_FFFF, "R5 wrap value");
    chk({31'd0, irq}, 32'd0, "R5 irq one cycle");
    rd(8'h00, 32'h0000_FFFE, "R5 keeps counting");
    wr(8'h08, 32'h00);
    rd(8'h04, 32'h20, "R10 expiry flag set");
    wr(8'h04, 32'h00);
    rd(8'h04, 32'h20, "R10 write 0 ignored");
    wr(8'h04, 32'h20);
    rd(8'h04, 32'h00, "R10 write 1 clears");

    // R4 divide by 65536
    wr(8'h00, 32'd0);
    wr(8'h08, 32'h8F);
    idle(65535);
    chk({31'd0, irq}, 32'd0, "R4 no tick before 65536");
    rd(8'h00, 32'd0, "R4 count held by divider");
    chk({31'd0, irq}, 32'd1, "R4 tick at 65536");
    rd(8'h00, 32'h0000_FFFF, "R4 wrap after long divide");
    wr(8'h08, 32'h00);
    wr(8'h04, 32'h20);

    // R6 periodic
    wr(8'h00, 32'd3);
    wr(8'h08, 32'h90);
    idle(3);
    rd(8'h00, 32'd0, "R6 count at zero");
    chk({31'd0, irq}, 32'd1, "R6 first irq");
    rd(8'h00, 32'd3, "R6 reload value");
    chk({31'd0, irq}, 32'd0, "R6 irq one cycle");
    rd(8'h00, 32'd2, "R6 counting again");
    idle(2);
    chk({31'd0, irq}, 32'd1, "R6 second period irq");
    wr(8'h08, 32'h00);

    // R7 one-shot
    wr(8'h00, 32'd2);
    wr(8'h08, 32'hA0);
    idle(2);
    chk({31'd0, irq}, 32'd0, "R7 no irq before expiry");
    idle(1);
    chk({31'd0, irq}, 32'd1, "R7 single irq");
    rd(8'h08, 32'h20, "R7 run bit cleared");
    for (int i = 0; i < 5; i++) begin
      chk({31'd0, irq}, 32'd0, "R7 no further irq");
      idle(1);
    end
    rd(8'h00, 32'd0, "R7 count stays zero");

    // R8 watchdog kicks, then expiry; R9 reset cause
    wr(8'h04, 32'h22);
    wr(8'h00, 32'd5);
    wr(8'h08, 32'hB0);
    for (int k = 0; k < 4; k++) begin
      idle(3);
      chk({31'd0, sys_rst_req}, 32'd0, "R8 kicked, no request");
      wr(8'h00, 32'd5);
    end
    rd(8'h00, 32'd5, "R8 kick reloads");
    idle(4);
    chk({31'd0, sys_rst_req}, 32'd0, "R8 no request before expiry");
    for (int c = 0; c < 4; c++) begin
      idle(1);
      chk({31'd0, sys_rst_req}, 32'd1, "R8 request held");
    end
    idle(1);
    chk({31'd0, sys_rst_req}, 32'd0, "R8 request released after 4");
    wr(8'h08, 32'h30);
    rd(8'h08, 32'h30, "R8 mode kept when stopped");
    rd(8'h04, 32'h22, "R9 cause flag set");
    wr(8'h04, 32'h00);
    rd(8'h04, 32'h22, "R9 write 0 ignored");
    wr(8'h04, 32'h02);
    rd(8'h04, 32'h20, "R9 write 1 clears cause");
    wr(8'h04, 32'h20);
    rd(8'h04, 32'h00, "R10 status clear");

    idle(3);
    chk(exp_q.size(), 32'd0, "scoreboard drained");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule